// File: doc/BRIEF.md
# Alternating-Threshold Supply Monitor Controller

This block drives a set of supply-good comparators, one per monitored rail. Each rail has a low-limit code and a high-limit code. On every cycle the block chooses which of the two codes each comparator receives. It then samples each comparator's digital result, filters it, and keeps two filtered fault flags per rail: one for the low limit and one for the high limit.

There are two ways to run it. In steady mode each rail keeps one limit permanently, and a per-rail high-select bit picks that limit. In alternating mode every rail swaps between the low and the high limit on a shared schedule, so a single comparator can watch both limits. Each comparator result is credited only to the flag of the limit that was applied while it was taken.

A build-time option produces a reset-path variant of the block. That variant always runs in steady mode.

Top module: `pp_thresh_mon`

## Requirements
- R1: In steady mode, a rail whose high-select bit is 0 receives its low-limit code on `thr_code`, and its `phase_ov` bit reads 0.
- R2: In steady mode, a rail whose high-select bit is 1 receives its high-limit code on `thr_code`, and its `phase_ov` bit reads 1.
- R3: Alternating mode is active when `pp_en` is 1, every `ov_sel` bit is 0, and the instance is not the reset-path variant. In this mode all rails share one phase (`phase_ov` is all-0 or all-1). Each phase lasts `phase_len` cycles, and a value of 0 is treated as 1.
- R4: If `pp_en` is 1 while any `ov_sel` bit is set, `cfg_err` reads 1 in the same cycle, and each rail stays in steady mode following its own `ov_sel` bit.
- R5: Once alternating mode becomes active, the first phase is the low phase (`phase_ov` = 0) and it lasts the full `phase_len` cycles.
- R6: The reset-path variant (`POR_MODE`=1) ignores `pp_en`. It always runs in steady mode and never raises `cfg_err`.
- R7: A comparator input of 1 means the rail is past the applied limit. A flag changes to a new value only after `FILT_N` consecutive valid samples that differ from its current value. Any valid sample equal to the flag restarts the count.
- R8: Comparator samples are discarded for 4 cycles after each change of a rail's applied limit and for 4 cycles after reset. The cycle in which the new limit first appears counts as the first of the 4.
- R9: While a rail's high limit is applied, its low flag does not change. While its low limit is applied, its high flag does not change.
- R10: During reset, all flags read 0 and `phase_ov` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ov_sel | input | NCH | Per-rail high-limit select for steady mode |
| pp_en | input | 1 | Alternating-mode request |
| phase_len | input | LEN_W | Cycles per alternating phase |
| uv_code | input | NCH*CODE_W | Low-limit codes, rail i at bits [i*CODE_W +: CODE_W] |
| ov_code | input | NCH*CODE_W | High-limit codes, same packing |
| cmp_in | input | NCH | Comparator results, 1 = past the applied limit |
| thr_code | output | NCH*CODE_W | Code applied to each comparator |
| phase_ov | output | NCH | 1 = high limit applied on that rail |
| uv_flag | output | NCH | Filtered low-limit fault per rail |
| ov_flag | output | NCH | Filtered high-limit fault per rail |
| cfg_err | output | 1 | Alternating mode requested with a high-select bit set |

## Verification
The main overlap is a phase switch landing on a filter that is part-way through counting or that has just reached `FILT_N`. To provoke it, the bench runs alternating mode with a short `phase_len` while holding the comparators steady. It then flips the comparators during the high phase and checks, cycle by cycle, which flag moves and when. The expected edges come from a simple count: 4 discarded cycles after each swap, then `FILT_N` samples. The bench also checks that the flag of the idle phase holds its value across the swap. A second overlap is entry into alternating mode in the same cycle as a settle window, for example straight after reset; that case is judged from the phase sequence measured from the first clock edge.

// File: rtl/pp_mon_pkg.sv
package pp_mon_pkg;
    // applied-limit phase of one rail
    typedef enum logic {
        PH_UV = 1'b0,
        PH_OV = 1'b1
    } phase_e;

    // cycles of comparator data dropped after a limit change
    localparam int unsigned SETTLE_CYC = 4;
endpackage

// File: rtl/pp_mon_seq.sv
module pp_mon_seq #(
    parameter int unsigned NCH      = 3,
    parameter int unsigned LEN_W    = 8,
    parameter bit          POR_MODE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   ov_sel,
    input  logic             pp_en,
    input  logic [LEN_W-1:0] phase_len,
    output logic [NCH-1:0]   sel_q,
    output logic             cfg_err
);
    import pp_mon_pkg::*;

    typedef struct packed {
        logic             pp;
        phase_e           ph;
        logic [LEN_W-1:0] cnt;
        logic [NCH-1:0]   sel;
    } seq_s;

    seq_s s_d, s_q;
    logic req_d;
    logic pp_ok_d;
    logic last_d;

    always_comb begin
        req_d   = pp_en && !POR_MODE;
        pp_ok_d = req_d && (ov_sel == '0);
        cfg_err = req_d && (ov_sel != '0);
        last_d  = (phase_len <= LEN_W'(1)) || (s_q.cnt == phase_len - LEN_W'(1));
        s_d     = s_q;
        if (!pp_ok_d) begin
            s_d.pp  = 1'b0;
            s_d.ph  = PH_UV;
            s_d.cnt = '0;
            s_d.sel = ov_sel;
        end else if (!s_q.pp) begin
            s_d.pp  = 1'b1;
            s_d.ph  = PH_UV;
            s_d.cnt = '0;
            s_d.sel = '0;
        end else begin
            if (last_d) begin
                s_d.ph  = (s_q.ph == PH_UV) ? PH_OV : PH_UV;
                s_d.cnt = '0;
            end else begin
                s_d.cnt = s_q.cnt + LEN_W'(1);
            end
            s_d.sel = {NCH{s_d.ph == PH_OV}};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{pp: 1'b0, ph: PH_UV, cnt: '0, sel: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign sel_q = s_q.sel;

    // R4: a bad request leaves every rail on its own select
    a_r4_cfg_steady: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> (sel_q == $past(ov_sel)));

    // R3: every rail shares the phase in alternating mode
    a_r3_uniform_phase: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pp |-> (sel_q == '0 || sel_q == '1));

    // R5: entry always lands on the low phase
    a_r5_first_uv: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.pp) |-> (sel_q == '0));

    generate
        if (POR_MODE) begin : g_por_chk
            // R6: the reset-path variant never alternates
            a_r6_por_steady: assert property (@(posedge clk) disable iff (!rst_n)
                !s_q.pp && !cfg_err);
        end
    endgenerate
endmodule

// File: rtl/pp_mon_filt.sv
module pp_mon_filt #(
    parameter int unsigned FILT_N = 3,
    parameter int unsigned SETTLE = pp_mon_pkg::SETTLE_CYC
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic cmp,
    output logic uv_flag,
    output logic ov_flag
);
    localparam int unsigned CNT_W = $clog2(FILT_N + 1);
    localparam int unsigned SET_W = $clog2(SETTLE + 1);

    typedef struct packed {
        logic             prev;
        logic [SET_W-1:0] settle;
        logic [CNT_W-1:0] uv_cnt;
        logic [CNT_W-1:0] ov_cnt;
        logic             uv_flag;
        logic             ov_flag;
    } filt_s;

    filt_s f_d, f_q;
    logic  take_d;

    always_comb begin
        f_d    = f_q;
        take_d = 1'b0;
        if (sel != f_q.prev) begin
            f_d.prev   = sel;
            f_d.settle = SET_W'(SETTLE - 1);
            f_d.uv_cnt = '0;
            f_d.ov_cnt = '0;
        end else if (f_q.settle != '0) begin
            f_d.settle = f_q.settle - SET_W'(1);
        end else begin
            take_d = 1'b1;
        end

        if (take_d && !sel) begin
            if (cmp == f_q.uv_flag) begin
                f_d.uv_cnt = '0;
            end else if (f_q.uv_cnt == CNT_W'(FILT_N - 1)) begin
                f_d.uv_flag = cmp;
                f_d.uv_cnt  = '0;
            end else begin
                f_d.uv_cnt = f_q.uv_cnt + CNT_W'(1);
            end
        end

        if (take_d && sel) begin
            if (cmp == f_q.ov_flag) begin
                f_d.ov_cnt = '0;
            end else if (f_q.ov_cnt == CNT_W'(FILT_N - 1)) begin
                f_d.ov_flag = cmp;
                f_d.ov_cnt  = '0;
            end else begin
                f_d.ov_cnt = f_q.ov_cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '{prev: 1'b0, settle: SET_W'(SETTLE), uv_cnt: '0,
                     ov_cnt: '0, uv_flag: 1'b0, ov_flag: 1'b0};
        end else begin
            f_q <= f_d;
        end
    end

    assign uv_flag = f_q.uv_flag;
    assign ov_flag = f_q.ov_flag;

    // R8: nothing is credited while the settle window runs
    a_r8_settle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.settle != '0) |=> ($stable(uv_flag) && $stable(ov_flag)));

    // R9: the flag of the idle phase holds
    a_r9_uv_hold: assert property (@(posedge clk) disable iff (!rst_n)
        sel |=> $stable(uv_flag));
    a_r9_ov_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> $stable(ov_flag));

    // R7: run counters stay below the filter length
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.uv_cnt < CNT_W'(FILT_N)) && (f_q.ov_cnt < CNT_W'(FILT_N)));
endmodule

// File: rtl/pp_thresh_mon.sv
module pp_thresh_mon #(
    parameter int unsigned NCH      = 3,
    parameter int unsigned CODE_W   = 6,
    parameter int unsigned LEN_W    = 8,
    parameter int unsigned FILT_N   = 3,
    parameter bit          POR_MODE = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH-1:0]        ov_sel,
    input  logic                  pp_en,
    input  logic [LEN_W-1:0]      phase_len,
    input  logic [NCH*CODE_W-1:0] uv_code,
    input  logic [NCH*CODE_W-1:0] ov_code,
    input  logic [NCH-1:0]        cmp_in,
    output logic [NCH*CODE_W-1:0] thr_code,
    output logic [NCH-1:0]        phase_ov,
    output logic [NCH-1:0]        uv_flag,
    output logic [NCH-1:0]        ov_flag,
    output logic                  cfg_err
);
    logic [NCH-1:0] sel_q;

    pp_mon_seq #(
        .NCH      (NCH),
        .LEN_W    (LEN_W),
        .POR_MODE (POR_MODE)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ov_sel    (ov_sel),
        .pp_en     (pp_en),
        .phase_len (phase_len),
        .sel_q     (sel_q),
        .cfg_err   (cfg_err)
    );

    assign phase_ov = sel_q;

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_rail
            assign thr_code[i*CODE_W +: CODE_W] =
                sel_q[i] ? ov_code[i*CODE_W +: CODE_W] : uv_code[i*CODE_W +: CODE_W];

            pp_mon_filt #(
                .FILT_N (FILT_N)
            ) u_filt (
                .clk     (clk),
                .rst_n   (rst_n),
                .sel     (sel_q[i]),
                .cmp     (cmp_in[i]),
                .uv_flag (uv_flag[i]),
                .ov_flag (ov_flag[i])
            );
        end
    endgenerate
endmodule

// File: tb/pp_thresh_mon_test.sv
`timescale 1ns/1ps
module pp_thresh_mon_test;
    localparam int NCH = 3;
    localparam int CW  = 6;
    localparam int LW  = 8;
    localparam int FN  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] ov_sel = '0;
    logic pp_en = 1'b0;
    logic [LW-1:0] phase_len = 8'd10;
    logic [NCH*CW-1:0] uv_code = {6'd12, 6'd11, 6'd10};
    logic [NCH*CW-1:0] ov_code = {6'd42, 6'd41, 6'd40};
    logic [NCH-1:0] cmp_in = '0;
    logic [NCH*CW-1:0] thr_code, thr_code_p;
    logic [NCH-1:0] phase_ov, uv_flag, ov_flag;
    logic [NCH-1:0] phase_ov_p, uv_flag_p, ov_flag_p;
    logic cfg_err, cfg_err_p;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    pp_thresh_mon #(.NCH(NCH), .CODE_W(CW), .LEN_W(LW), .FILT_N(FN), .POR_MODE(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .ov_sel(ov_sel), .pp_en(pp_en), .phase_len(phase_len),
        .uv_code(uv_code), .ov_code(ov_code), .cmp_in(cmp_in), .thr_code(thr_code),
        .phase_ov(phase_ov), .uv_flag(uv_flag), .ov_flag(ov_flag), .cfg_err(cfg_err));

    pp_thresh_mon #(.NCH(NCH), .CODE_W(CW), .LEN_W(LW), .FILT_N(FN), .POR_MODE(1'b1)) uut_por (
        .clk(clk), .rst_n(rst_n), .ov_sel(ov_sel), .pp_en(pp_en), .phase_len(phase_len),
        .uv_code(uv_code), .ov_code(ov_code), .cmp_in(cmp_in), .thr_code(thr_code_p),
        .phase_ov(phase_ov_p), .uv_flag(uv_flag_p), .ov_flag(ov_flag_p), .cfg_err(cfg_err_p));

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic run(input int n);
        repeat (n) step();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        run(2);
        rst_n = 1'b1;
    endtask

    // codes: low limit of rail i is 10+i, high limit is 40+i
    task automatic check_thr(input string req, input logic [NCH-1:0] exp_sel);
        for (int i = 0; i < NCH; i++) begin
            check(req, int'(thr_code[i*CW +: CW]), exp_sel[i] ? 40 + i : 10 + i);
        end
        check(req, int'(phase_ov), int'(exp_sel));
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R10: reset state
        cmp_in = '1;
        rst_n = 1'b0;
        run(3);
        check("R10 uv", int'(uv_flag), 0);
        check("R10 ov", int'(ov_flag), 0);
        check("R10 phase", int'(phase_ov), 0);
        cmp_in = '0;

        // R1 R2 R4 R5 R6: every select pattern with and without the request
        for (int e = 0; e < 2; e++) begin
            for (int s = 0; s < 8; s++) begin
                pp_en = e[0];
                ov_sel = s[2:0];
                phase_len = 8'd4;
                do_reset();
                check("R4 cfg_err", int'(cfg_err), (e == 1 && s != 0) ? 1 : 0);
                step();
                if (e == 1 && s == 0) check_thr("R5 entry uv", 3'b000);
                else if (s == 0) check_thr("R1 steady low", 3'b000);
                else check_thr("R2 steady select", s[2:0]);
                check("R6 por phase", int'(phase_ov_p), s);
                check("R6 por cfg", int'(cfg_err_p), 0);
            end
        end

        // R3 R5: phase sequence for several lengths, 0 acts as 1
        for (int li = 0; li < 5; li++) begin
            int len;
            int eff;
            case (li)
                0: len = 0;
                1: len = 1;
                2: len = 2;
                3: len = 5;
                default: len = 7;
            endcase
            eff = (len == 0) ? 1 : len;
            pp_en = 1'b1;
            ov_sel = '0;
            phase_len = LW'(len);
            do_reset();
            for (int k = 1; k <= 4 * eff + 2; k++) begin
                step();
                check_thr("R3 alternation", ((((k - 1) / eff) % 2) == 1) ? 3'b111 : 3'b000);
            end
        end

        // R7 R8: steady low, constant fault from reset
        pp_en = 1'b0;
        ov_sel = '0;
        cmp_in = '1;
        do_reset();
        run(6);
        check("R8 uv still settling", int'(uv_flag), 0);
        step();
        check("R7 uv set", int'(uv_flag), 7);
        check("R9 ov untouched", int'(ov_flag), 0);

        // R7: runs of two never flip the flag
        cmp_in = '0;
        do_reset();
        run(5);
        for (int r = 0; r < 4; r++) begin
            cmp_in = '1; step();
            step();
            cmp_in = '0; step();
            check("R7 glitch rejected", int'(uv_flag), 0);
        end
        cmp_in = '1;
        run(2);
        check("R7 two of three", int'(uv_flag), 0);
        step();
        check("R7 third sample sets", int'(uv_flag), 7);
        cmp_in = '0;
        run(2);
        check("R7 clear pending", int'(uv_flag), 7);
        step();
        check("R7 clear done", int'(uv_flag), 0);

        // R2 R8: steady high, switch cycle counts inside settle
        ov_sel = '1;
        cmp_in = '1;
        do_reset();
        run(7);
        check("R8 ov still settling", int'(ov_flag), 0);
        step();
        check("R7 ov set", int'(ov_flag), 7);
        check("R9 uv untouched", int'(uv_flag), 0);

        // R3 R8 R9: alternation with length 10 and a flip during high phase
        ov_sel = '0;
        pp_en = 1'b1;
        phase_len = 8'd10;
        cmp_in = '1;
        do_reset();
        run(6);
        check("R8 pp uv settling", int'(uv_flag), 0);
        step();
        check("R7 pp uv set", int'(uv_flag), 7);
        check("R6 por steady in pp", int'(phase_ov_p), 0);
        run(10);
        check("R8 pp ov settling", int'(ov_flag), 0);
        check("R3 high phase", int'(phase_ov), 7);
        step();
        check("R7 pp ov set", int'(ov_flag), 7);
        cmp_in = '0;
        run(2);
        check("R7 pp ov holding", int'(ov_flag), 7);
        step();
        check("R7 pp ov cleared", int'(ov_flag), 0);
        check("R9 uv held through high", int'(uv_flag), 7);
        run(4);
        check("R9 uv held in settle", int'(uv_flag), 7);
        check("R3 back to low", int'(phase_ov), 0);
        run(2);
        check("R7 uv pending", int'(uv_flag), 7);
        step();
        check("R7 uv cleared", int'(uv_flag), 0);
        check("R9 ov held in low", int'(ov_flag), 0);

        // R4 R6: request with a select set stays steady for many cycles
        ov_sel = 3'b010;
        pp_en = 1'b1;
        phase_len = 8'd2;
        do_reset();
        for (int k = 0; k < 20; k++) begin
            step();
            check("R4 steady on error", int'(phase_ov), 2);
            check("R4 cfg flag", int'(cfg_err), 1);
            check("R6 por no error", int'(cfg_err_p), 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule